// File: doc/BRIEF.md
# Two-Level Nested Interrupt Request Unit

This block collects interrupt requests for a small 8-bit microcontroller core. It handles five sources: two external inputs, two timer overflows and one serial channel. Each source has a flag that is set whenever its condition occurs. The flag is set even when the source is disabled. Once per machine cycle the flags are copied into a sample register, with both the global enable and the per-source enables applied. At the next instruction boundary the unit picks one sampled request and starts a forced long call to that source's vector.

The forced call takes six machine cycles. The unit raises a busy level with the vector while the call runs and a one-cycle done pulse when it ends. Each source is assigned to a low or a high priority level. A two-bit in-service register records which levels are active. A new request is accepted only when it is of strictly higher priority than everything in service. A return-from-interrupt strobe releases the highest active level.

Software reaches three registers over a byte-wide register port: the enables, the priority bits and the flags. The enable register uses address 0xA8.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A pulse on `src_evt[i]` sets flag i at the next clock edge regardless of any enable bit. The flag register reads at address 0x98, with bit i holding source i (0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial 0). A write to that address loads bits 4:0, and an event in the same cycle wins.
- R2: The enable register at address 0xA8 is readable and writable in all 8 bits. Bit 7 is the global enable and bits 4:0 enable source 0..4 by index. Bits 6 and 5 are stored but have no interrupt effect.
- R3: A request can be raised only from the sample register. The sample register is loaded on cycles with `mc_tick` high, from the flags ANDed with their enable bits and with bit 7. With bit 7 at 0, with a source's enable at 0, or while `mc_tick` stays low, no call starts.
- R4: A call starts only in a cycle with `mc_tick` and `insn_bound` both high and no call in progress. `call_busy` then stays high for 6 machine cycles, and `call_done` pulses for one clock when the call ends. With `mc_tick` and `insn_bound` held high and nothing in service, `call_done` is seen 8 clock edges after the edge that captures the event. This is 7 machine cycles counted from the sampling edge.
- R5: The vector of source i is 0x0003 + 8*i: 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. It is held on `call_vec` from the start of the call onward.
- R6: Of several sampled requests, the high-priority ones are taken first. Within one level the lowest source index is taken first.
- R7: The priority register at address 0xB8 puts source i at the high level when bit i is 1. A high request may nest over a low service. No request is taken while a service of equal or higher level is active.
- R8: A pulse on `reti` clears the highest set bit of the in-service state, so that waiting requests of the released level can be taken.
- R9: Starting a call clears the flag of source 0..3 that was taken. The serial flag (bit 4) stays set until software writes it to 0.
- R10: After reset the enable, priority and flag registers read 0x00, and `call_busy` and `call_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | One-clock strobe per machine cycle |
| insn_bound | input | 1 | Core is at an instruction boundary |
| src_evt | input | 5 | Source condition pulses, bit i is source i |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data (combinational) |
| reti | input | 1 | Return-from-interrupt strobe |
| call_busy | output | 1 | Forced long call in progress |
| call_vec | output | 16 | Vector address of the current or last call |
| call_done | output | 1 | One-clock pulse when the forced call completes |

## Verification
A source event is captured in the flag one edge later. The event reaches the sample register on the next machine-cycle edge, and the call starts one edge after that. `call_done` then follows 6 machine cycles later, 8 edges after the event in total. When the request is already sampled and is released by `reti` or by raising `insn_bound`, `call_done` comes 7 edges later. The bench drives on falling edges and counts falling edges until `call_done`. It compares that count with the figure computed from the call length and checks the vector at the same point. "Nothing is taken" cases are watched for a fixed window of falling edges, and no busy or done may appear within it.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned SRC_N = 5;
  localparam int unsigned IDX_W = $clog2(SRC_N);

  typedef logic [SRC_N-1:0] src_vec_t;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } level_e;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
    level_e           level;
  } pick_t;

  // lowest index set in v (0 when v is empty)
  function automatic logic [IDX_W-1:0] lowest_set(input src_vec_t v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // vector address of a source: base + idx * stride
  function automatic logic [15:0] vector_of(input logic [IDX_W-1:0] idx,
                                            input logic [15:0] base,
                                            input logic [15:0] stride);
    return base + (16'(idx) * stride);
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_i,
  input  logic     wr_i,
  input  src_vec_t wdata_i,
  input  src_vec_t hw_clr_i,
  input  logic     tick_i,
  input  src_vec_t en_mask_i,
  output src_vec_t flags_o,
  output src_vec_t samp_o
);
  src_vec_t flag_q, flag_d, samp_q;

  for (genvar g = 0; g < SRC_N; g++) begin : g_bit
    // event has priority over both software write and hardware clear
    assign flag_d[g] = set_i[g] | (wr_i ? wdata_i[g] : (flag_q[g] & ~hw_clr_i[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      samp_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (tick_i) samp_q <= flag_q & en_mask_i;
    end
  end

  assign flags_o = flag_q;
  assign samp_o  = samp_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  src_vec_t   samp_i,
  input  src_vec_t   prio_i,
  input  logic [1:0] isr_i,
  output pick_t      pick_o
);
  src_vec_t pend_hi, pend_lo;
  logic     hi_ok, lo_ok;

  assign pend_hi = samp_i & prio_i;
  assign pend_lo = samp_i & ~prio_i;
  assign hi_ok   = ~isr_i[1];
  assign lo_ok   = (isr_i == 2'b00);

  always_comb begin
    pick_o = '{valid: 1'b0, idx: '0, level: LVL_LOW};
    if ((|pend_hi) && hi_ok) begin
      pick_o = '{valid: 1'b1, idx: lowest_set(pend_hi), level: LVL_HIGH};
    end else if ((|pend_lo) && lo_ok) begin
      pick_o = '{valid: 1'b1, idx: lowest_set(pend_lo), level: LVL_LOW};
    end
  end
endmodule

// File: rtl/irq_service_track.sv
module irq_service_track
  import irq_pkg::*;
#(
  parameter int unsigned CALL_CYC   = 6,
  parameter logic [15:0] VEC_BASE   = 16'h0003,
  parameter logic [15:0] VEC_STRIDE = 16'h0008
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             bound_i,
  input  pick_t            pick_i,
  input  logic             reti_i,
  output logic             ack_o,
  output logic [IDX_W-1:0] ack_idx_o,
  output logic [1:0]       isr_o,
  output logic             busy_o,
  output logic [15:0]      vec_o,
  output logic             done_o
);
  localparam int unsigned CNT_W = $clog2(CALL_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       isr_q, isr_d;
  logic [15:0]      vec_q;
  logic             done_q;

  assign ack_o     = tick_i & bound_i & pick_i.valid & (cnt_q == '0);
  assign ack_idx_o = pick_i.idx;

  always_comb begin
    isr_d = isr_q;
    if (reti_i) begin
      if (isr_q[1]) isr_d[1] = 1'b0;
      else          isr_d[0] = 1'b0;
    end
    if (ack_o) begin
      if (pick_i.level == LVL_HIGH) isr_d[1] = 1'b1;
      else                          isr_d[0] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      isr_q  <= '0;
      vec_q  <= '0;
      done_q <= 1'b0;
    end else begin
      isr_q  <= isr_d;
      done_q <= tick_i && (cnt_q == CNT_W'(1));
      if (ack_o) begin
        cnt_q <= CNT_W'(CALL_CYC);
        vec_q <= vector_of(pick_i.idx, VEC_BASE, VEC_STRIDE);
      end else if (tick_i && (cnt_q != '0)) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign isr_o  = isr_q;
  assign busy_o = (cnt_q != '0);
  assign vec_o  = vec_q;
  assign done_o = done_q;
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned CALL_CYC    = 6,
  parameter logic [15:0] VEC_BASE    = 16'h0003,
  parameter logic [15:0] VEC_STRIDE  = 16'h0008,
  parameter logic [7:0]  EN_ADDR     = 8'hA8,
  parameter logic [7:0]  PRIO_ADDR   = 8'hB8,
  parameter logic [7:0]  FLAG_ADDR   = 8'h98,
  parameter logic [4:0]  HWCLR_MASK  = 5'b01111
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mc_tick,
  input  logic        insn_bound,
  input  logic [4:0]  src_evt,
  input  logic        sfr_we,
  input  logic [7:0]  sfr_addr,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic        reti,
  output logic        call_busy,
  output logic [15:0] call_vec,
  output logic        call_done
);
  localparam int unsigned GIE_BIT = 7;

  logic [7:0]       en_q;
  src_vec_t         prio_q;
  src_vec_t         flags, samp, en_src, hw_clr;
  pick_t            pick;
  logic             ack_fire;
  logic [IDX_W-1:0] ack_idx;
  logic             ack_level;
  logic [1:0]       isr;
  logic             reti_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      prio_q <= '0;
    end else if (sfr_we) begin
      if (sfr_addr == EN_ADDR)   en_q   <= sfr_wdata;
      if (sfr_addr == PRIO_ADDR) prio_q <= sfr_wdata[SRC_N-1:0];
    end
  end

  assign en_src = en_q[SRC_N-1:0] & {SRC_N{en_q[GIE_BIT]}};
  assign hw_clr = ack_fire ? ((src_vec_t'(1) << ack_idx) & HWCLR_MASK) : '0;

  irq_flag_bank u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (src_evt),
    .wr_i      (sfr_we && (sfr_addr == FLAG_ADDR)),
    .wdata_i   (sfr_wdata[SRC_N-1:0]),
    .hw_clr_i  (hw_clr),
    .tick_i    (mc_tick),
    .en_mask_i (en_src),
    .flags_o   (flags),
    .samp_o    (samp)
  );

  irq_arbiter u_arb (
    .samp_i (samp),
    .prio_i (prio_q),
    .isr_i  (isr),
    .pick_o (pick)
  );

  irq_service_track #(
    .CALL_CYC   (CALL_CYC),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_svc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (mc_tick),
    .bound_i   (insn_bound),
    .pick_i    (pick),
    .reti_i    (reti),
    .ack_o     (ack_fire),
    .ack_idx_o (ack_idx),
    .isr_o     (isr),
    .busy_o    (call_busy),
    .vec_o     (call_vec),
    .done_o    (call_done)
  );

  assign ack_level = (pick.level == LVL_HIGH);
  assign reti_clr  = reti & (|isr);

  always_comb begin
    sfr_rdata = '0;
    if (sfr_addr == EN_ADDR)   sfr_rdata = en_q;
    if (sfr_addr == PRIO_ADDR) sfr_rdata = 8'(prio_q);
    if (sfr_addr == FLAG_ADDR) sfr_rdata = 8'(flags);
  end
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int unsigned CALL_CYC = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mc_tick,
  input logic [4:0] src_evt,
  input logic [4:0] flags,
  input logic [4:0] samp,
  input logic       ack_fire,
  input logic [2:0] ack_idx,
  input logic       ack_level,
  input logic [1:0] isr,
  input logic       reti_clr,
  input logic       call_busy,
  input logic       call_done
);
  int unsigned ticks_in_call;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ticks_in_call <= 0;
    else if (ack_fire)             ticks_in_call <= 0;
    else if (call_busy && mc_tick) ticks_in_call <= ticks_in_call + 1;
  end

  AST_FLAG_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != 5'b0) |=> ((flags & $past(src_evt)) == $past(src_evt))); // R1

  AST_ACK_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |-> samp[ack_idx]); // R3

  AST_ONE_CALL_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |-> !call_busy); // R4

  AST_CALL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    call_done |-> (ticks_in_call == CALL_CYC)); // R4

  AST_STRICT_NESTING: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |-> (ack_level ? !isr[1] : (isr == 2'b00))); // R7

  AST_RETI_RELEASES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_clr && !ack_fire) |=> ($countones(isr) + 1 == $countones($past(isr)))); // R8
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.CALL_CYC(CALL_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mc_tick   (mc_tick),
  .src_evt   (src_evt),
  .flags     (flags),
  .samp      (samp),
  .ack_fire  (ack_fire),
  .ack_idx   (ack_idx),
  .ack_level (ack_level),
  .isr       (isr),
  .reti_clr  (reti_clr),
  .call_busy (call_busy),
  .call_done (call_done)
);

// File: tb/irq_nest_ctrl_tb.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb;
  localparam int CALL_CYC = 6;
  localparam logic [7:0] A_EN = 8'hA8, A_PRIO = 8'hB8, A_FLAG = 8'h98;
  localparam int LAT_EVT = 2 + CALL_CYC;  // flag edge, sample edge, then call
  localparam int LAT_RDY = 1 + CALL_CYC;  // request already sampled

  logic        clk = 1'b0;
  logic        rst_n, mc_tick, insn_bound, sfr_we, reti;
  logic [4:0]  src_evt;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
  logic        call_busy, call_done;
  logic [15:0] call_vec;

  int checks = 0, failures = 0, cycles = 0;

  always #10 clk = ~clk;

  irq_nest_ctrl u_dut (.*);

  function automatic logic [15:0] exp_vec(input int i);
    return 16'h0003 + 16'(8 * i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    sfr_addr = a; #1; d = sfr_rdata;
  endtask

  task automatic pulse_evt(input logic [4:0] m);
    src_evt = m;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  task automatic expect_call(input string req, input int i, input int lat);
    int k = 0;
    while (!call_done && k < 40) begin
      @(negedge clk);
      k++;
    end
    chk({req, " done seen"}, 32'(call_done), 32'd1);
    if (lat > 0) chk({req, " latency"}, 32'(k), 32'(lat));
    chk({req, " vector"}, 32'(call_vec), 32'(exp_vec(i)));
  endtask

  task automatic expect_none(input string req, input int n);
    logic seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (call_busy || call_done) seen = 1'b1;
    end
    chk(req, 32'(seen), 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; mc_tick = 1'b1; insn_bound = 1'b1; sfr_we = 1'b0; reti = 1'b0;
    src_evt = '0; sfr_addr = '0; sfr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(A_EN, d);   chk("R10 enable reset", 32'(d), 32'h00);
    rd(A_PRIO, d); chk("R10 priority reset", 32'(d), 32'h00);
    rd(A_FLAG, d); chk("R10 flag reset", 32'(d), 32'h00);
    chk("R10 busy reset", 32'(call_busy), 32'd0);
    chk("R10 done reset", 32'(call_done), 32'd0);

    // R2 full readback
    wr(A_EN, 8'hFF); rd(A_EN, d); chk("R2 enable readback", 32'(d), 32'hFF);
    wr(A_EN, 8'h00); rd(A_EN, d); chk("R2 enable cleared", 32'(d), 32'h00);

    // R1 disabled sources still latch their flags
    for (int i = 0; i < 5; i++) begin
      pulse_evt(5'(1 << i));
      rd(A_FLAG, d);
      chk("R1 flag latches while disabled", 32'(d), 32'((2 << i) - 1));
    end
    expect_none("R3 no call with enables off", 12);
    wr(A_FLAG, 8'h00); rd(A_FLAG, d); chk("R1 flag write clears", 32'(d), 32'h00);

    // R3 global enable off blocks; R2 bits 6 and 5 have no effect
    wr(A_EN, 8'h7F);
    pulse_evt(5'h01);
    expect_none("R3 R2 global enable off", 12);
    wr(A_FLAG, 8'h00);

    // R4 R5 R9 sweep over every source alone
    for (int i = 0; i < 5; i++) begin
      wr(A_EN, 8'h80 | 8'(1 << i));
      pulse_evt(5'(1 << i));
      expect_call("R4 R5 single source", i, LAT_EVT);
      rd(A_FLAG, d);
      chk("R9 flag after call", 32'(d), (i == 4) ? 32'h10 : 32'h00);
      wr(A_FLAG, 8'h00);
      do_reti();
    end

    // R6 all five together, fixed order within one level
    wr(A_EN, 8'h9F);
    pulse_evt(5'h1F);
    for (int i = 0; i < 5; i++) begin
      expect_call("R6 same-level order", i, (i == 0) ? LAT_EVT : LAT_RDY);
      if (i == 4) wr(A_FLAG, 8'h00);
      do_reti();
    end

    // R6 R7 high level taken first
    wr(A_PRIO, 8'h10);
    rd(A_PRIO, d); chk("R7 priority readback", 32'(d), 32'h10);
    wr(A_EN, 8'h93);
    pulse_evt(5'h13);
    expect_call("R6 R7 high level first", 4, LAT_EVT);
    wr(A_FLAG, 8'h03);
    do_reti();
    expect_call("R6 low after high", 0, LAT_RDY);
    do_reti();
    expect_call("R6 low second", 1, LAT_RDY);
    do_reti();

    // R7 R8 nesting: timer 0 high over external 0 low
    wr(A_PRIO, 8'h02);
    wr(A_EN, 8'h83);
    pulse_evt(5'h01);
    expect_call("R7 low service", 0, LAT_EVT);
    pulse_evt(5'h02);
    expect_call("R7 high nests over low", 1, LAT_EVT);
    pulse_evt(5'h01);
    expect_none("R7 low waits under two levels", 12);
    do_reti();
    expect_none("R8 R7 equal level still waits", 12);
    do_reti();
    expect_call("R8 released after second return", 0, LAT_RDY);
    do_reti();

    // R7 equal high level does not nest
    wr(A_PRIO, 8'h03);
    pulse_evt(5'h01);
    expect_call("R7 high service", 0, LAT_EVT);
    pulse_evt(5'h02);
    expect_none("R7 equal high waits", 12);
    do_reti();
    expect_call("R8 equal taken after return", 1, LAT_RDY);
    do_reti();

    // R3 no sampling without machine-cycle strobe
    wr(A_PRIO, 8'h00);
    wr(A_EN, 8'h81);
    mc_tick = 1'b0;
    pulse_evt(5'h01);
    expect_none("R3 no call with tick low", 10);
    mc_tick = 1'b1;
    expect_call("R3 call after tick resumes", 0, LAT_EVT);
    do_reti();

    // R4 waits for instruction boundary
    wr(A_EN, 8'h84);
    insn_bound = 1'b0;
    pulse_evt(5'h04);
    expect_none("R4 no call off boundary", 10);
    insn_bound = 1'b1;
    expect_call("R4 call at boundary", 2, LAT_RDY);
    do_reti();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule